// File: doc/BRIEF.md
# Read-Sequence Command Unlock Detector

This block watches the access stream of an SRAM-style memory interface. Each clock cycle carries at most one access event, which has an address, a read/write type and a valid strobe. The block looks for a fixed chain of six reads to particular addresses. When a read completes that chain, the block raises a store request for one cycle. The memory controller uses that request to start a nonvolatile save. Because the command is carried only by ordinary reads, the memory stays pin-compatible with a plain SRAM.

Any access that does not continue the chain breaks it: a write, or a read to an address other than the expected one. The access that broke the chain is then checked again as a possible opening step. Whether the output drivers are enabled does not matter: a read counts from its type alone. While the surrounding device is busy, for example during the transfer that a request started, its accesses are ignored and the chain is cleared. A three-bit progress count shows how many steps have matched so far.

Top module: `seq_unlock_detector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `progress` is 0 and `store_req` is 0.
- R2: A valid read (`acc_valid`=1, `acc_write`=0, `busy`=0) to the next expected address increases `progress` by one on the next clock edge. `progress` equals the number of chain steps matched so far, from 0 to 5.
- R3: The chain addresses, in the order they must be read, are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 (15-bit addresses). The sixth matching read drives `store_req` to 1 for exactly one cycle, starting after the clock edge that captures it. On that same edge `progress` returns to 0.
- R4: A valid write resets `progress` to 0 at any step, even when it targets the expected address. A write never raises `store_req`.
- R5: A valid read to an address that is neither the expected one nor 0x0E38 resets `progress` to 0.
- R6: A valid read of 0x0E38 that does not continue the chain sets `progress` to 1, because it restarts the chain at step one.
- R7: In any cycle with `busy`=1, the access inputs are ignored. `progress` becomes 0 and `store_req` stays 0, even for a read that would complete the chain.
- R8: A cycle with `acc_valid`=0 and `busy`=0 leaves `progress` unchanged, and `store_req` is 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access event is present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 15 | Address of the access |
| busy | input | 1 | Device busy; accesses are discarded and the chain is cleared |
| store_req | output | 1 | One-cycle request to start a nonvolatile store |
| progress | output | 3 | Number of chain steps matched so far |

## Verification
The assertions assume that `acc_write` and `acc_addr` have defined values whenever `acc_valid` is high. They also assume that reset is held for at least one clock edge before any access arrives. The bench changes every input only on the falling clock edge, holds reset for several cycles at the start, and drives the address and type with known values even in idle cycles. At every chain depth it applies each way of breaking the chain: a write, a wrong read, a restarting read, a busy cycle and idle gaps. It also sweeps the address space at the opening step. This keeps the stimulus within those assumptions.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  localparam int ADDR_W = 15;
  localparam int STEPS  = 6;
  localparam int PROG_W = $clog2(STEPS);
  localparam int LAST   = STEPS - 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PROG_W-1:0] prog_t;

  // Address that must be read at chain position idx (0-based).
  function automatic addr_t step_addr(input int idx);
    addr_t a;
    case (idx)
      0:       a = addr_t'(15'h0E38);
      1:       a = addr_t'(15'h31C7);
      2:       a = addr_t'(15'h03E0);
      3:       a = addr_t'(15'h3C1F);
      4:       a = addr_t'(15'h303F);
      default: a = addr_t'(15'h0FC0);
    endcase
    return a;
  endfunction

  // Chain position after one cycle of input.
  function automatic prog_t after_access(input prog_t cur,
                                         input logic  valid,
                                         input logic  is_write,
                                         input logic  busy_in,
                                         input logic  hit_next,
                                         input logic  hit_first);
    prog_t n;
    if (busy_in)             n = '0;
    else if (!valid)         n = cur;
    else if (is_write)       n = '0;
    else if (hit_next)       n = (cur == prog_t'(LAST)) ? '0 : cur + prog_t'(1);
    else if (hit_first)      n = prog_t'(1);
    else                     n = '0;
    return n;
  endfunction

  // A read that finishes the whole chain.
  function automatic logic completes(input prog_t cur,
                                     input logic  valid,
                                     input logic  is_write,
                                     input logic  busy_in,
                                     input logic  hit_next);
    return valid && !is_write && !busy_in && hit_next && (cur == prog_t'(LAST));
  endfunction

endpackage

// File: rtl/unlock_addr_match.sv
module unlock_addr_match
  import unlock_pkg::*;
(
  input  logic  [ADDR_W-1:0] addr,
  input  logic  [PROG_W-1:0] cur,
  output logic               hit_next,
  output logic               hit_first,
  output logic  [STEPS-1:0]  hit_vec
);

  // One comparator per chain position.
  for (genvar g = 0; g < STEPS; g++) begin : g_cmp
    assign hit_vec[g] = (addr == step_addr(g));
  end

  always_comb begin
    hit_next = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (cur == prog_t'(i)) hit_next = hit_vec[i];
    end
  end

  assign hit_first = hit_vec[0];

  // The chain addresses are all distinct, so at most one comparator fires (R3).
  always_comb begin
    assert_distinct_steps_R3: assert ($onehot0(hit_vec))
      else $error("more than one chain address matched");
  end

endmodule

// File: rtl/unlock_step_fsm.sv
module unlock_step_fsm
  import unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              busy,
  input  logic              hit_next,
  input  logic              hit_first,
  output logic [PROG_W-1:0] progress,
  output logic              store_req,
  output logic              ev_advance,
  output logic              ev_complete,
  output logic              ev_abort
);

  prog_t prog_q, prog_d;
  logic  req_q;
  logic  ev_read;

  assign ev_read     = acc_valid && !acc_write && !busy;
  assign ev_complete = completes(prog_q, acc_valid, acc_write, busy, hit_next);
  assign ev_advance  = ev_read && hit_next && !ev_complete;
  assign ev_abort    = (acc_valid && !busy) && !ev_advance && !ev_complete;
  assign prog_d      = after_access(prog_q, acc_valid, acc_write, busy, hit_next, hit_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= '0;
      req_q  <= 1'b0;
    end else begin
      prog_q <= prog_d;
      req_q  <= ev_complete;
    end
  end

  assign progress  = prog_q;
  assign store_req = req_q;

  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    prog_q <= prog_t'(LAST))
    else $error("progress beyond last step");

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    ev_advance |=> prog_q == $past(prog_q) + prog_t'(1))
    else $error("advance did not increment");

  assert_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req)
    else $error("store request longer than one cycle");

  assert_req_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(store_req) |-> $past(acc_valid && !acc_write && !busy && prog_q == prog_t'(LAST)))
    else $error("store request without a final read");

  assert_req_clears_R3: assert property (@(posedge clk) disable iff (rst)
    store_req |-> prog_q == '0)
    else $error("progress not cleared with the request");

  assert_write_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write) |=> (prog_q == '0 && !store_req))
    else $error("write did not clear the chain");

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_abort && !acc_write && hit_first) |=> prog_q == prog_t'(1))
    else $error("restart read did not set step one");

  assert_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (prog_q == '0 && !store_req))
    else $error("busy cycle left chain state");

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !busy) |=> $stable(prog_q))
    else $error("idle cycle changed progress");

endmodule

// File: rtl/seq_unlock_detector.sv
module seq_unlock_detector
  import unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              busy,
  output logic              store_req,
  output logic [PROG_W-1:0] progress
);

  logic             hit_next, hit_first;
  logic [STEPS-1:0] hit_vec;
  logic             ev_advance, ev_complete, ev_abort;

  unlock_addr_match u_match (
    .addr      (acc_addr),
    .cur       (progress),
    .hit_next  (hit_next),
    .hit_first (hit_first),
    .hit_vec   (hit_vec)
  );

  unlock_step_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .busy        (busy),
    .hit_next    (hit_next),
    .hit_first   (hit_first),
    .progress    (progress),
    .store_req   (store_req),
    .ev_advance  (ev_advance),
    .ev_complete (ev_complete),
    .ev_abort    (ev_abort)
  );

  // A completing access is never also counted as an advance or an abort (R3).
  always_comb begin
    assert_event_excl_R3: assert ($onehot0({ev_advance, ev_complete, ev_abort}))
      else $error("access classified twice");
  end

  // Right after reset the chain is idle (R1).
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (progress == '0 && !store_req))
    else $error("state not cleared by reset");

  // Any hit vector state is consistent with a single expected position (R2).
  assert_hitvec_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_next && !hit_first) |-> hit_vec != '0)
    else $error("next-step hit without comparator");

endmodule

// File: tb/test_seq_unlock_detector.sv
`timescale 1ns/1ps
module test_seq_unlock_detector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [14:0] acc_addr  = '0;
  logic        busy      = 1'b0;
  logic        store_req;
  logic [2:0]  progress;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_prog = 0;
  int exp_req  = 0;
  bit done = 0;

  logic [14:0] chain [6];

  always #2 clk = ~clk;

  seq_unlock_detector i_seq_unlock_detector (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .busy(busy), .store_req(store_req), .progress(progress)
  );

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Bench reference: restated from the requirements.
  task automatic model(input bit v, input bit w, input logic [14:0] a, input bit b);
    int nxt;
    exp_req = 0;
    nxt = exp_prog;
    if (b) nxt = 0;
    else if (v) begin
      if (w) nxt = 0;
      else if (a == chain[exp_prog]) begin
        if (exp_prog == 5) begin nxt = 0; exp_req = 1; end
        else nxt = exp_prog + 1;
      end
      else if (a == chain[0]) nxt = 1;
      else nxt = 0;
    end
    exp_prog = nxt;
  endtask

  task automatic acc(input bit v, input bit w, input logic [14:0] a, input bit b,
                     input string req);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; busy = b;
    model(v, w, a, b);
    @(posedge clk);
    #1;
    check(req, progress, exp_prog);
    check(req, store_req, exp_req);
  endtask

  task automatic idle(input string req);
    acc(0, 0, 15'h7FFF, 0, req);
  endtask

  task automatic walk(input int k, input string req);
    for (int i = 0; i < k; i++) acc(1, 0, chain[i], 0, req);
  endtask

  initial begin
    chain[0] = 15'h0E38; chain[1] = 15'h31C7; chain[2] = 15'h03E0;
    chain[3] = 15'h3C1F; chain[4] = 15'h303F; chain[5] = 15'h0FC0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", progress, 0);
    check("R1", store_req, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", progress, 0);
    check("R1", store_req, 0);

    // R2 / R3: full chain, then the pulse must drop.
    walk(6, "R3");
    check("R3", store_req, 1);
    idle("R3");
    check("R3", store_req, 0);

    for (int k = 0; k < 6; k++) begin
      walk(k, "R2");
      check("R2", progress, k);
      acc(1, 1, chain[k], 0, "R4");           // write to the expected address
      check("R4", progress, 0);

      walk(k, "R2");
      acc(1, 0, chain[k] ^ 15'h0101, 0, "R5"); // wrong read
      walk(k, "R2");
      if (k > 0) begin
        acc(1, 0, chain[0], 0, "R6");          // restarting read
        check("R6", progress, 1);
        acc(1, 1, 15'h0000, 0, "R4");
      end

      walk(k, "R2");
      for (int j = 0; j < 3; j++) idle("R8");
      check("R8", progress, k);
      acc(1, 0, chain[k], 1, "R7");            // busy swallows the expected read
      check("R7", progress, 0);
      acc(0, 0, 15'h0, 1, "R7");
      check("R7", store_req, 0);
    end

    // R7: busy during the sixth read never requests a store.
    walk(5, "R2");
    acc(1, 0, chain[5], 1, "R7");
    check("R7", store_req, 0);

    // R3: a complete chain interrupted by idle gaps still succeeds.
    for (int i = 0; i < 6; i++) begin
      idle("R8");
      acc(1, 0, chain[i], 0, "R3");
    end
    check("R3", store_req, 1);

    // R5 / R6: address sweep at the opening step.
    for (int a = 0; a < 32768; a += 37) begin
      acc(1, 0, 15'(a), 0, "R5");
      acc(1, 1, 15'h0, 0, "R4");
    end
    acc(1, 0, chain[0], 0, "R6");
    check("R6", progress, 1);
    // Sixth address read early is a plain wrong read.
    acc(1, 0, chain[5], 0, "R5");
    check("R5", progress, 0);

    // R3: two chains back to back give two separate pulses.
    walk(6, "R3");
    walk(6, "R3");
    check("R3", store_req, 1);
    idle("R3");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule